// File: doc/BRIEF.md
# TLB associative search unit

This block carries out the privileged TLB search operation of a 32-bit processor. It holds a 64-entry, fully associative translation table that is loaded through a plain write port. When a start strobe arrives with a decoded search instruction, the block forms an effective address from the operand values. It then compares that address, the current search ID and the search address-space bit against every entry at once.

The operation does not return a translation. It returns the index of the matching entry, zero-extended, for the target register. When the record bit is set, it also returns a 4-bit condition field whose found bit lets software test for a miss. In user state the operation is refused: the block raises a privilege flag and writes nothing. All results are registered and are announced by a one-cycle done pulse.

Top module: `tlb_search_unit`

## Requirements
- R1: A start strobe is accepted only when instr[31:26] equals 31 and instr[10:1] equals 914. For any other word the strobe has no effect: done, rt_we and cr_we stay 0 in the next cycle.
- R2: The clock edge that samples an accepted start registers all results. done is 1 for exactly the following cycle and is 0 in cycles with no accepted start before them.
- R3: The effective address is rb_val plus a base. The base is the literal 0 when the RA field instr[20:16] is 0, and ra_val otherwise.
- R4: An entry matches only when it is valid, its space bit equals srch_ts, and its TID is 0 or equals srch_tid. Its page number (EA bits 31:12) must also agree with the effective address above the page size. Size codes 0, 1, 2 and 3 select 4 KB, 64 KB, 1 MB and 16 MB, which ignore 0, 4, 8 and 12 low page-number bits. Codes 4 to 7 never match. hit reports whether a match was found.
- R5: Outside user state an accepted search sets rt_we and sets rt_idx to the RT field instr[25:21]. rt_data carries the matching index in bits 5:0 with bits 31:6 cleared. On a miss rt_data is 0.
- R6: When several entries match, the lowest index is reported.
- R7: When the record bit instr[0] is 1 outside user state, cr_we is 1 and cr0 is {LT=0, GT=0, EQ=hit, SO=xer_so}. cr0[3] is LT and cr0[0] is SO.
- R8: When the record bit is 0, cr_we stays 0.
- R9: When user_mode is 1, an accepted search sets priv_err together with done. rt_we, cr_we and hit stay 0.
- R10: wr_en writes entry wr_idx at the clock edge. A search started in that same cycle compares against the table as it was before the write. Reset invalidates every entry.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 6 | Entry to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_epn | input | 20 | Page number to store |
| wr_size | input | 3 | Page-size code to store |
| wr_tid | input | 8 | TID to store |
| wr_ts | input | 1 | Address-space bit to store |
| start | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| ra_val | input | 32 | Contents of register RA |
| rb_val | input | 32 | Contents of register RB |
| xer_so | input | 1 | Summary overflow bit |
| srch_tid | input | 8 | Search ID from the MMU control register |
| srch_ts | input | 1 | Search space bit from the MMU control register |
| user_mode | input | 1 | Processor is in problem state |
| done | output | 1 | Results valid this cycle |
| rt_we | output | 1 | Target register write enable |
| rt_idx | output | 5 | Target register number |
| rt_data | output | 32 | Target register value |
| cr_we | output | 1 | Condition field write enable |
| cr0 | output | 4 | Condition field {LT,GT,EQ,SO} |
| priv_err | output | 1 | Privilege violation |
| hit | output | 1 | A matching entry was found |

## Verification
Every result appears exactly one clock edge after the edge that samples start, and only for that one cycle. The bench drives start on a falling edge and samples all outputs on the next falling edge. It then checks on the falling edge after that, which confirms that done has dropped again. Table writes use the same half-cycle discipline. The same-cycle write case drives the write and the search together and expects the old contents. A reference table in the bench predicts every index for each sweep.

// File: rtl/tlbs_pkg.sv
package tlbs_pkg;
    localparam int XLEN       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int EPN_W      = XLEN - PAGE_SHIFT;
    localparam int TID_W      = 8;
    localparam int SIZE_W     = 3;
    localparam int SIZE_STEP  = 4;
    localparam int NUM_SIZES  = 4;
    localparam logic [5:0] OPC_PRIMARY  = 6'd31;
    localparam logic [9:0] OPC_EXTENDED = 10'd914;

    typedef enum logic [SIZE_W-1:0] {
        PG_4K  = 3'd0,
        PG_64K = 3'd1,
        PG_1M  = 3'd2,
        PG_16M = 3'd3
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        logic [EPN_W-1:0]  epn;
        logic [SIZE_W-1:0] size;
        logic [TID_W-1:0]  tid;
        logic              ts;
    } tlb_entry_t;

    typedef struct packed {
        logic [5:0] opcd;
        logic [4:0] rt;
        logic [4:0] ra;
        logic [4:0] rb;
        logic [9:0] xo;
        logic       rc;
    } instr_fields_t;

    function automatic logic size_supported(logic [SIZE_W-1:0] code);
        return int'(code) < NUM_SIZES;
    endfunction

    function automatic logic [EPN_W-1:0] size_mask(logic [SIZE_W-1:0] code);
        logic [EPN_W-1:0] m;
        m = '1;
        for (int k = 0; k < EPN_W; k++) begin
            if (size_supported(code) && (k < SIZE_STEP * int'(code))) m[k] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/tlbs_decode.sv
module tlbs_decode
    import tlbs_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  rb_val,
    output logic             is_search,
    output logic [4:0]       rt_f,
    output logic             rc,
    output logic [EPN_W-1:0] ea_epn
);
    instr_fields_t   f;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] ea;
    logic [PAGE_SHIFT+5-1:0] unused_bits;

    assign f         = instr_fields_t'(instr);
    assign is_search = (f.opcd == OPC_PRIMARY) && (f.xo == OPC_EXTENDED);
    assign rt_f      = f.rt;
    assign rc        = f.rc;
    // RA field of zero selects a literal zero base, not register 0
    assign base      = (f.ra == 5'd0) ? '0 : ra_val;
    assign ea        = base + rb_val;
    assign ea_epn    = ea[XLEN-1:PAGE_SHIFT];
    assign unused_bits = {ea[PAGE_SHIFT-1:0], f.rb};
endmodule

// File: rtl/tlbs_array.sv
module tlbs_array
    import tlbs_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  tlb_entry_t         wr_entry,
    input  logic [EPN_W-1:0]   ea_epn,
    input  logic [TID_W-1:0]   srch_tid,
    input  logic               srch_ts,
    output logic [ENTRIES-1:0] match
);
    tlb_entry_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i].valid <= 1'b0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [EPN_W-1:0] msk;
        logic             tid_ok;
        logic             addr_ok;
        assign msk     = size_mask(tbl[g].size);
        assign tid_ok  = (tbl[g].tid == '0) || (tbl[g].tid == srch_tid);
        assign addr_ok = ((tbl[g].epn ^ ea_epn) & msk) == '0;
        assign match[g] = tbl[g].valid && size_supported(tbl[g].size)
                       && (tbl[g].ts == srch_ts) && tid_ok && addr_ok;
    end
endmodule

// File: rtl/tlbs_prienc.sv
module tlbs_prienc #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign found = |req;
endmodule

// File: rtl/tlb_search_unit.sv
module tlb_search_unit
    import tlbs_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [EPN_W-1:0]  wr_epn,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic              wr_ts,
    input  logic              start,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic              xer_so,
    input  logic [TID_W-1:0]  srch_tid,
    input  logic              srch_ts,
    input  logic              user_mode,
    output logic              done,
    output logic              rt_we,
    output logic [4:0]        rt_idx,
    output logic [XLEN-1:0]   rt_data,
    output logic              cr_we,
    output logic [3:0]        cr0,
    output logic              priv_err,
    output logic              hit
);
    logic               is_search;
    logic [4:0]         rt_f;
    logic               rc;
    logic [EPN_W-1:0]   ea_epn;
    logic [ENTRIES-1:0] match;
    logic               found;
    logic [IDX_W-1:0]   idx;
    logic               go;
    logic               exec;
    tlb_entry_t         wr_entry;

    assign wr_entry = '{valid: wr_valid, epn: wr_epn, size: wr_size, tid: wr_tid, ts: wr_ts};

    tlbs_decode u_dec (
        .instr     (instr),
        .ra_val    (ra_val),
        .rb_val    (rb_val),
        .is_search (is_search),
        .rt_f      (rt_f),
        .rc        (rc),
        .ea_epn    (ea_epn)
    );

    tlbs_array #(.ENTRIES(ENTRIES)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ea_epn   (ea_epn),
        .srch_tid (srch_tid),
        .srch_ts  (srch_ts),
        .match    (match)
    );

    tlbs_prienc #(.N(ENTRIES)) u_pri (
        .req   (match),
        .found (found),
        .idx   (idx)
    );

    assign go   = start && is_search;
    assign exec = go && !user_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            rt_we    <= 1'b0;
            rt_idx   <= '0;
            rt_data  <= '0;
            cr_we    <= 1'b0;
            cr0      <= '0;
            priv_err <= 1'b0;
            hit      <= 1'b0;
        end else begin
            done     <= go;
            priv_err <= go && user_mode;
            rt_we    <= exec;
            rt_idx   <= exec ? rt_f : '0;
            hit      <= exec && found;
            rt_data  <= (exec && found) ? XLEN'(idx) : '0;
            cr_we    <= exec && rc;
            cr0      <= (exec && rc) ? {2'b00, found, xer_so} : 4'b0000;
        end
    end
endmodule

// File: rtl/tlbs_chk.sv
module tlbs_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] instr,
    input logic        user_mode,
    input logic        xer_so,
    input logic        done,
    input logic        rt_we,
    input logic [31:0] rt_data,
    input logic        cr_we,
    input logic [3:0]  cr0,
    input logic        priv_err,
    input logic        hit
);
    logic legal;
    assign legal = (instr[31:26] == 6'd31) && (instr[10:1] == 10'd914);

    AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (rst)
        (start && !legal) |=> !done); // R1
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && legal) |=> done); // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(start)); // R2
    AST_RT_ZEXT: assert property (@(posedge clk) disable iff (rst)
        rt_we |-> (rt_data[31:6] == 26'd0)); // R5
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rt_we && !hit) |-> (rt_data == 32'd0)); // R5
    AST_CR_FORM: assert property (@(posedge clk) disable iff (rst)
        (start && legal && !user_mode && instr[0]) |=>
        (cr_we && cr0[3:2] == 2'b00 && cr0[1] == hit && cr0[0] == $past(xer_so))); // R7
    AST_RC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && legal && !instr[0]) |=> !cr_we); // R8
    AST_PRIV_USER: assert property (@(posedge clk) disable iff (rst)
        (start && legal && user_mode) |=> (priv_err && done)); // R9
    AST_PRIV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        priv_err |-> (!rt_we && !cr_we && !hit)); // R9
endmodule

bind tlb_search_unit tlbs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .instr     (instr),
    .user_mode (user_mode),
    .xer_so    (xer_so),
    .done      (done),
    .rt_we     (rt_we),
    .rt_data   (rt_data),
    .cr_we     (cr_we),
    .cr0       (cr0),
    .priv_err  (priv_err),
    .hit       (hit)
);

// File: tb/tlb_search_unit_test.sv
module tlb_search_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_valid, wr_ts;
    logic [5:0]  wr_idx;
    logic [19:0] wr_epn;
    logic [2:0]  wr_size;
    logic [7:0]  wr_tid;
    logic        start, xer_so, srch_ts, user_mode;
    logic [31:0] instr, ra_val, rb_val;
    logic [7:0]  srch_tid;
    logic        done, rt_we, cr_we, priv_err, hit;
    logic [4:0]  rt_idx;
    logic [31:0] rt_data;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;

    logic        m_valid [64];
    logic [19:0] m_epn   [64];
    logic [2:0]  m_size  [64];
    logic [7:0]  m_tid   [64];
    logic        m_ts    [64];

    always #4 clk = ~clk;

    tlb_search_unit uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [9:0] xo, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic rc);
        return {6'd31, rt, ra, 5'd9, xo, rc};
    endfunction

    function automatic int ref_idx(input logic [31:0] ea, input logic [7:0] sid, input logic sts);
        for (int i = 0; i < 64; i++) begin
            if (m_valid[i] && m_size[i] <= 3 && m_ts[i] == sts &&
                (m_tid[i] == 8'd0 || m_tid[i] == sid) &&
                ((m_epn[i] >> (4 * m_size[i])) == (ea[31:12] >> (4 * m_size[i]))))
                return i;
        end
        return -1;
    endfunction

    task automatic wr(input int idx, input logic v, input logic [19:0] epn,
                      input logic [2:0] sz, input logic [7:0] tid, input logic ts);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_epn = epn;
        wr_size = sz; wr_tid = tid; wr_ts = ts;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = v; m_epn[idx] = epn; m_size[idx] = sz; m_tid[idx] = tid; m_ts[idx] = ts;
    endtask

    task automatic search(input logic [4:0] ra_f, input logic [31:0] rav, input logic [31:0] rbv,
                          input logic [7:0] sid, input logic sts, input logic rc,
                          input logic so, input logic um);
        logic [31:0] ea;
        int e;
        logic [4:0] rtf;
        ea  = ((ra_f == 5'd0) ? 32'd0 : rav) + rbv;   // R3
        e   = ref_idx(ea, sid, sts);
        rtf = 5'(ra_f + 5'd3);
        @(negedge clk);
        start = 1'b1; instr = mk(10'd914, rtf, ra_f, rc); ra_val = rav; rb_val = rbv;
        srch_tid = sid; srch_ts = sts; xer_so = so; user_mode = um;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", 32'(done), 32'd1);
        if (um) begin
            chk("R9 priv_err", 32'(priv_err), 32'd1);
            chk("R9 writes", {29'd0, rt_we, cr_we, hit}, 32'd0);
        end else begin
            chk("R9 no priv_err", 32'(priv_err), 32'd0);
            chk("R5 rt_we/rt_idx", {26'd0, rt_we, rt_idx}, {26'd0, 1'b1, rtf});
            chk("R3 R4 R5 R6 rt_data", rt_data, (e >= 0) ? 32'(e) : 32'd0);
            chk("R4 hit", 32'(hit), 32'(e >= 0));
            if (rc) chk("R7 cr", {27'd0, cr_we, cr0}, {27'd0, 1'b1, 2'b00, 1'(e >= 0), so});
            else    chk("R8 cr_we", 32'(cr_we), 32'd0);
        end
        @(negedge clk);
        chk("R2 done pulse", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_epn = 0; wr_size = 0;
        wr_tid = 0; wr_ts = 0; start = 0; instr = 0; ra_val = 0; rb_val = 0;
        xer_so = 0; srch_tid = 0; srch_ts = 0; user_mode = 0;
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 0; m_epn[i] = 0; m_size[i] = 0; m_tid[i] = 0; m_ts[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 outputs after reset", {rt_data[15:0], 2'b0, done, rt_we, rt_idx, cr_we, cr0, priv_err, hit},
            32'd0);
        chk("R11 rt_data after reset", rt_data, 32'd0);

        // empty table: every search misses
        search(5'd0, 32'd0, 32'h0000_1000, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0); // R10

        // R1: wrong extended opcode is ignored
        @(negedge clk);
        start = 1'b1; instr = mk(10'd915, 5'd4, 5'd0, 1'b1);
        @(negedge clk);
        start = 1'b0;
        chk("R1 ignored word", {29'd0, done, rt_we, cr_we}, 32'd0);
        @(negedge clk);
        start = 1'b1; instr = {6'd30, 5'd4, 5'd0, 5'd0, 10'd914, 1'b1};
        @(negedge clk);
        start = 1'b0;
        chk("R1 ignored primary", {29'd0, done, rt_we, cr_we}, 32'd0);

        // load entries 0..62; entry 62 invalid, size codes 4 never match
        for (int i = 0; i < 63; i++) begin
            wr(i, (i != 62), 20'(((i + 1) << 12) | ((i * 37) & 'hfff)), 3'(i % 5),
               (i % 7 == 0) ? 8'd0 : 8'(i + 3), (i % 3 == 1));
        end
        // R6: duplicate of entry 20 at entry 50
        wr(50, 1'b1, m_epn[20], m_size[20], m_tid[20], m_ts[20]);

        for (int i = 0; i < 64; i++) begin
            int szl;
            logic [31:0] pg, addr, rav;
            logic [7:0] sid;
            szl  = (m_size[i] > 3) ? 3 : int'(m_size[i]);
            pg   = 32'd1 << (12 + 4 * szl);
            addr = {m_epn[i], 12'h000} ^ (32'(i * 7919) & (pg - 1));
            sid  = (m_tid[i] == 8'd0) ? 8'h5A : m_tid[i];
            rav  = 32'h0123_4000 + 32'(i);
            search(5'd5, rav, addr - rav, sid, m_ts[i], i[0], i[1], 1'b0);
            search(5'd0, 32'hDEAD_BEEF, addr, sid, m_ts[i], !i[0], i[2], 1'b0);
            search(5'd7, 32'd0, addr, sid, !m_ts[i], 1'b1, 1'b0, 1'b0);
            search(5'd7, 32'd0, addr, m_tid[i] ^ 8'h80, m_ts[i], 1'b1, 1'b1, 1'b0);
            search(5'd0, 32'd0, addr ^ pg, sid, m_ts[i], 1'b1, 1'b0, 1'b0);
            if (i % 16 == 0) search(5'd0, 32'd0, addr, sid, m_ts[i], 1'b1, 1'b1, 1'b1);
        end

        // R10: write and search of entry 63 in the same cycle sees the old (invalid) entry
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd63; wr_valid = 1'b1; wr_epn = 20'hF0000;
        wr_size = 3'd0; wr_tid = 8'd0; wr_ts = 1'b0;
        start = 1'b1; instr = mk(10'd914, 5'd2, 5'd0, 1'b1); ra_val = 0; rb_val = 32'hF000_0123;
        srch_tid = 8'd1; srch_ts = 1'b0; user_mode = 1'b0; xer_so = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        chk("R10 same-cycle write unseen", {30'd0, hit, done}, 32'd1);
        m_valid[63] = 1; m_epn[63] = 20'hF0000; m_size[63] = 0; m_tid[63] = 0; m_ts[63] = 0;
        search(5'd0, 32'd0, 32'hF000_0123, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0); // R10 now hits

        // R10: reset invalidates the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
        search(5'd0, 32'd0, 32'hF000_0123, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule